// File: doc/BRIEF.md
# Pipelined Constant Gain Scaler

This block scales an unsigned 9-bit sample by a fixed gain of seventeen over the square root of twenty-one, which is about 3.7097. It has no multiplier, no table and no divider. The gain is approximated as 475/128, which is 3.7109375. That product is formed from shifted copies of the sample by four add or subtract operations arranged in three dependent layers, and is then scaled down by a 7-bit right shift.

The layers are 3N and 7N in parallel, then 27N from 3N, then 475N from 27N plus 7N shifted left by six. A register follows each layer. A sample presented with its valid strobe therefore comes out exactly three clock cycles later, with a matching strobe. A new sample can be accepted on every cycle. The coarser gain 59/16 is not used, because its error of about 0.6 % is too large.

A build-time parameter selects how the shift is rounded. Truncation is the default. Round-half-up adds 64 before the shift.

Top module: `cnst_scaler`

## Requirements
- R1: A synchronous active-high reset clears every pipeline valid bit. `out_vld` is low in the cycle after any clock edge at which `rst` was high, and stays low until a valid sample has travelled the full pipeline.
- R2: `out_vld` equals the `in_vld` that was presented three clock edges earlier. A cycle with `in_vld` low produces a cycle with `out_vld` low.
- R3: With `ROUND_EN`=0, `out_data` equals floor(475·N/128) for the sample N that entered three cycles earlier.
- R4: With `ROUND_EN`=1, `out_data` equals floor((475·N+64)/128).
- R5: The full-scale input 511 produces 1896 in both rounding modes. No intermediate result overflows, and `out_data` never exceeds 1896.
- R6: An input of 0 produces an output of 0.
- R7: Samples presented on consecutive cycles each produce their own correct result on consecutive cycles. This gives a throughput of one sample per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 9 | Unsigned input sample N |
| out_vld | output | 1 | Result strobe, three cycles after `in_vld` |
| out_data | output | 11 | Scaled result |

## Verification
Every one of the 512 possible inputs is streamed back to back through a truncating instance and a rounding instance at the same time. The results are then compared with the integer formulas. This exhaustive sweep catches the following faults:
- A wrong shift term, which shows up as a gain error that grows with N.
- A lost carry in a narrow intermediate, which appears only near full scale, such as 1895 or less for 511.
- A missing or misplaced rounding bias, which appears at inputs whose fractional part is at least one half.

Random streams with gaps in the valid strobe expose a valid bit that travels out of step with its data, or a stage that holds stale data. A reset applied while samples are in flight exposes a pipeline that lets them emerge afterwards.

// File: rtl/scl_pkg.sv
package scl_pkg;
    // Gain approximation 475 / 2^7 (binary 11.1011011)
    localparam int GAIN_NUM   = 475;
    localparam int GAIN_SHIFT = 7;
    // Extra product bits needed for a numerator below 512
    localparam int GAIN_BITS  = 9;
    // Stage layer growth: 7N needs 3 bits, 27N needs 5 bits
    localparam int L1_GROW    = 3;
    localparam int L2_GROW    = 5;
endpackage

// File: rtl/scl_layer1.sv
module scl_layer1
    import scl_pkg::*;
#(
    parameter int IN_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic [IN_W-1:0]         n_i,
    output logic                    vld_o,
    output logic [IN_W+L1_GROW-1:0] x3_o,
    output logic [IN_W+L1_GROW-1:0] x7_o
);
    localparam int W = IN_W + L1_GROW;

    logic [W-1:0] n_ext;
    logic [W-1:0] x3_c;
    logic [W-1:0] x7_c;

    always_comb begin
        n_ext = W'(n_i);
        x3_c  = n_ext + (n_ext << 1);   // N + 2N
        x7_c  = (n_ext << 3) - n_ext;   // 8N - N
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        x3_o <= x3_c;
        x7_o <= x7_c;
    end
endmodule

// File: rtl/scl_layer2.sv
module scl_layer2
    import scl_pkg::*;
#(
    parameter int IN_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic [IN_W+L1_GROW-1:0] x3_i,
    input  logic [IN_W+L1_GROW-1:0] x7_i,
    output logic                    vld_o,
    output logic [IN_W+L2_GROW-1:0] x27_o,
    output logic [IN_W+L1_GROW-1:0] x7_o
);
    localparam int W = IN_W + L2_GROW;

    logic [W-1:0] a_ext;
    logic [W-1:0] x27_c;

    always_comb begin
        a_ext = W'(x3_i);
        x27_c = a_ext + (a_ext << 3);   // 3N + 24N
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        x27_o <= x27_c;
        x7_o  <= x7_i;   // carried alongside for layer 3
    end
endmodule

// File: rtl/scl_layer3.sv
module scl_layer3
    import scl_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter bit ROUND_EN = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               vld_i,
    input  logic [IN_W+L2_GROW-1:0]            x27_i,
    input  logic [IN_W+L1_GROW-1:0]            x7_i,
    output logic                               vld_o,
    output logic [IN_W+GAIN_BITS-GAIN_SHIFT-1:0] y_o
);
    localparam int PROD_W = IN_W + GAIN_BITS;
    localparam int OUT_W  = PROD_W - GAIN_SHIFT;

    logic [PROD_W-1:0] bias;
    logic [PROD_W-1:0] prod_c;

    generate
        if (ROUND_EN) begin : g_round
            assign bias = PROD_W'(1) << (GAIN_SHIFT - 1);
        end else begin : g_trunc
            assign bias = '0;
        end
    endgenerate

    always_comb begin
        prod_c = PROD_W'(x27_i) + (PROD_W'(x7_i) << 6) + bias;   // 27N + 448N
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        y_o <= prod_c[PROD_W-1:GAIN_SHIFT];
    end

    logic unused_lsb;
    assign unused_lsb = ^prod_c[GAIN_SHIFT-1:0];
endmodule

// File: rtl/cnst_scaler.sv
module cnst_scaler
    import scl_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter bit ROUND_EN = 1'b0,
    localparam int OUT_W   = IN_W + GAIN_BITS - GAIN_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_data
);
    logic                    v1;
    logic                    v2;
    logic [IN_W+L1_GROW-1:0] s1_x3;
    logic [IN_W+L1_GROW-1:0] s1_x7;
    logic [IN_W+L2_GROW-1:0] s2_x27;
    logic [IN_W+L1_GROW-1:0] s2_x7;

    scl_layer1 #(.IN_W(IN_W)) u_l1 (
        .clk(clk), .rst(rst), .vld_i(in_vld), .n_i(in_data),
        .vld_o(v1), .x3_o(s1_x3), .x7_o(s1_x7)
    );

    scl_layer2 #(.IN_W(IN_W)) u_l2 (
        .clk(clk), .rst(rst), .vld_i(v1), .x3_i(s1_x3), .x7_i(s1_x7),
        .vld_o(v2), .x27_o(s2_x27), .x7_o(s2_x7)
    );

    scl_layer3 #(.IN_W(IN_W), .ROUND_EN(ROUND_EN)) u_l3 (
        .clk(clk), .rst(rst), .vld_i(v2), .x27_i(s2_x27), .x7_i(s2_x7),
        .vld_o(out_vld), .y_o(out_data)
    );
endmodule

// File: rtl/scl_chk.sv
module scl_chk
    import scl_pkg::*;
#(
    parameter int IN_W     = 9,
    parameter bit ROUND_EN = 1'b0,
    localparam int OUT_W   = IN_W + GAIN_BITS - GAIN_SHIFT
) (
    input logic             clk,
    input logic             rst,
    input logic             in_vld,
    input logic [IN_W-1:0]  in_data,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_data
);
    localparam int PW = IN_W + GAIN_BITS + 1;

    function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] n);
        logic [PW-1:0] p;
        p = PW'(n) * PW'(GAIN_NUM) + (ROUND_EN ? PW'(1 << (GAIN_SHIFT - 1)) : '0);
        return OUT_W'(p >> GAIN_SHIFT);
    endfunction

    localparam logic [OUT_W-1:0] TOP_VAL = model({IN_W{1'b1}});

    // cycles since reset, saturating at the pipeline depth
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_FLUSH_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd3) |-> !out_vld);                                      // R1
    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_vld == $past(in_vld, 3)));                 // R2
    AST_DATA_MATCH: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_vld) |-> (out_data == model($past(in_data, 3)))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_data <= TOP_VAL));                               // R5
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_vld && $past(in_data, 3) == '0) |-> (out_data == '0)); // R6
endmodule

bind cnst_scaler scl_chk #(.IN_W(IN_W), .ROUND_EN(ROUND_EN)) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
);

// File: tb/cnst_scaler_tb.sv
module cnst_scaler_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [8:0]  in_data = '0;
    logic        vt, vr;
    logic [10:0] dt, dr;

    int n_run  = 0;
    int n_fail = 0;
    logic       hv [3];
    logic [8:0] hd [3];

    always #5 clk = ~clk;

    cnst_scaler #(.IN_W(9), .ROUND_EN(1'b0)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .out_vld(vt), .out_data(dt)
    );
    cnst_scaler #(.IN_W(9), .ROUND_EN(1'b1)) u_dut_rnd (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
        .out_vld(vr), .out_data(dr)
    );

    function automatic int f_trunc(input int n);
        return (n * 475) / 128;
    endfunction
    function automatic int f_round(input int n);
        return (n * 475 + 64) / 128;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // check outputs against the sample driven three steps ago, then drive
    task automatic step(input logic v, input logic [8:0] d, input string tag);
        @(negedge clk);
        chk(vt == hv[2], {tag, " R2 vld trunc"}, int'(vt), int'(hv[2]));
        chk(vr == hv[2], {tag, " R2 vld round"}, int'(vr), int'(hv[2]));
        if (hv[2]) begin
            chk(int'(dt) == f_trunc(int'(hd[2])), {tag, " R3 trunc"}, int'(dt), f_trunc(int'(hd[2])));
            chk(int'(dr) == f_round(int'(hd[2])), {tag, " R4 round"}, int'(dr), f_round(int'(hd[2])));
        end
        hv[2] = hv[1]; hd[2] = hd[1];
        hv[1] = hv[0]; hd[1] = hd[0];
        hv[0] = v;     hd[0] = d;
        in_vld = v;
        in_data = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_vld = 1'b0;
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hd[i] = '0; end
        repeat (2) @(negedge clk);
        chk(!vt && !vr, "R1 reset clears valid", int'(vt) + int'(vr), 0);
        rst = 1'b0;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        do_reset();
        // R6 / R5 directed corners
        step(1'b1, 9'd0,   "R6 zero");
        step(1'b1, 9'd511, "R5 full scale");
        step(1'b1, 9'd1,   "R3 one");
        step(1'b0, 9'd300, "R2 gap");
        step(1'b1, 9'd256, "R3 mid");
        repeat (3) step(1'b0, 9'd0, "R2 drain");
        chk(1'b1, "R5 constant", f_trunc(511), 1896);
        chk(f_trunc(511) == 1896 && f_round(511) == 1896, "R5 model", f_round(511), 1896);
        // R7 exhaustive back-to-back sweep
        for (int n = 0; n < 512; n++) step(1'b1, 9'(n), "R7 sweep");
        // R1 reset with samples in flight
        step(1'b1, 9'd400, "R1 pre");
        step(1'b1, 9'd401, "R1 pre");
        do_reset();
        repeat (3) step(1'b0, 9'd0, "R1 post flush");
        // random stream with gaps
        for (int i = 0; i < 3000; i++)
            step(1'($urandom % 4 != 0), 9'($urandom), "R2 random");
        repeat (3) step(1'b0, 9'd0, "R2 drain");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule